// File: doc/BRIEF.md
# VBI Aspect Word Capture

This block sits behind a data slicer and picks up the 20-bit aspect word carried in the vertical blanking interval. The word has 14 payload bits, sent most significant first, followed by a 6-bit check code. The block accepts sliced bits only on one configured line per field. It counts them, runs the check code over the whole word, and keeps the first two payload bits as held aspect flags. The first is the full-mode (16:9) flag and the second is the letterbox flag. A separate flag reports whether the most recent complete word was sound.

The sliced bits arrive on a valid/ready stream. The block takes a bit in every cycle where `bit_valid` and `bit_ready` are both high. `bit_ready` is low only while the clear input `clr` is high. A bit offered while ready is low is not consumed, and the sender keeps it on the bus until it is taken. Bits offered outside the line window count as taken, and they are dropped. The line number and the field parity are plain inputs. A change of line number restarts word assembly.

Top module: `vbi_aspect_capture`

## Requirements
- R1: With `narrow`=1, bits are used only on line `NOM_F0` (default 20) when `field`=0 and on line `NOM_F1` (default 283) when `field`=1. Bits on any other line change no output.
- R2: With `narrow`=0, the lines one before and one after the nominal line of the current field are accepted as well.
- R3: Within one unchanged line number, a word is complete on exactly the 20th accepted bit. Further bits on that line are ignored. A change of `line_num` discards any partial word and restarts the count.
- R4: The check code uses generator x^6+x+1 with a zero preset, over the 14 payload bits, MSB first. It is carried in the last 6 bits of the word, MSB first.
- R5: When a complete word passes the check, `full_flag` takes payload bit 1 (the first bit received) and `lbox_flag` takes payload bit 2, and `word_ok` becomes 1. All three update on the clock edge that accepts the 20th bit.
- R6: When a complete word fails the check, `word_ok` becomes 0 and both flags keep their values.
- R7: Outputs change only on a word completion or a clear. Otherwise the flags are held whatever the value of `word_ok`.
- R8: `clr`=1 clears both flags, `word_ok` and any partial word on the next edge.
- R9: After `rst_n` is released, all outputs are 0 and `bit_ready` is 1.
- R10: `bit_ready` is 0 exactly while `clr` is 1, and a bit offered then is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_num | input | LINE_W | Current video line number |
| field | input | 1 | Field parity, 0 = first field |
| narrow | input | 1 | 1 = nominal line only, 0 = also the neighbouring lines |
| clr | input | 1 | Synchronous decoder clear, active high |
| bit_valid | input | 1 | Sliced bit present |
| bit_data | input | 1 | Sliced bit value |
| bit_ready | output | 1 | Block can take a bit |
| full_flag | output | 1 | Held full-mode flag |
| lbox_flag | output | 1 | Held letterbox flag |
| word_ok | output | 1 | Last complete word passed the check |

## Verification
The bench builds the block with its default parameters: a 10-bit line number, nominal lines 20 and 283, and a 20-bit word with a 6-bit code. With these values the real line numbers of both fields can be used, including the neighbouring lines 19, 21, 282 and 284. Words that straddle a line change, words with trailing extra bits and corrupted codes can all be reached in a few thousand cycles.

// File: rtl/vbi_cap_pkg.sv
package vbi_cap_pkg;
  typedef struct packed {
    logic full;
    logic lbox;
  } aspect_t;
endpackage

// File: rtl/vbi_line_gate.sv
module vbi_line_gate #(
  parameter int LINE_W = 10,
  parameter int NOM_F0 = 20,
  parameter int NOM_F1 = 283
) (
  input  logic [LINE_W-1:0] line_num,
  input  logic              field,
  input  logic              narrow,
  output logic              in_win
);
  localparam int SPAN = 1;
  logic [LINE_W-1:0] nom;
  logic [2*SPAN:0]   hit;

  assign nom = field ? LINE_W'(NOM_F1) : LINE_W'(NOM_F0);

  for (genvar k = 0; k <= 2*SPAN; k++) begin : g_cand
    if (k == SPAN) begin : g_centre
      assign hit[k] = (line_num == nom);
    end else begin : g_side
      assign hit[k] = !narrow && (line_num == nom + LINE_W'(k) - LINE_W'(SPAN));
    end
  end

  assign in_win = |hit;
endmodule

// File: rtl/vbi_word_track.sv
module vbi_word_track
  import vbi_cap_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int WORD_BITS = 20,
  localparam int CNT_W    = $clog2(WORD_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [LINE_W-1:0] line_num,
  input  logic              offer,
  input  logic              bit_data,
  output logic              take,
  output logic              first,
  output logic              last,
  output aspect_t           cap_q
);
  logic [LINE_W-1:0] line_q;
  logic [CNT_W-1:0]  cnt_q, eff_cnt;

  assign eff_cnt = (line_num != line_q) ? '0 : cnt_q;
  assign take    = offer && (eff_cnt < CNT_W'(WORD_BITS));
  assign first   = take && (eff_cnt == '0);
  assign last    = take && (eff_cnt == CNT_W'(WORD_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      cnt_q  <= '0;
      cap_q  <= '0;
    end else begin
      line_q <= line_num;
      if (clr) begin
        cnt_q <= '0;
        cap_q <= '0;
      end else if (take) begin
        cnt_q <= eff_cnt + CNT_W'(1);
        if (eff_cnt == CNT_W'(0)) cap_q.full <= bit_data;
        if (eff_cnt == CNT_W'(1)) cap_q.lbox <= bit_data;
      end else begin
        cnt_q <= eff_cnt;
      end
    end
  end
endmodule

// File: rtl/vbi_crc_lfsr.sv
module vbi_crc_lfsr #(
  parameter int              CRC_W    = 6,
  parameter logic [CRC_W-1:0] CRC_POLY = 6'h03
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic first,
  input  logic bit_data,
  output logic zero_next
);
  logic [CRC_W-1:0] crc_q, base, nxt;
  logic             fb;

  assign base      = first ? '0 : crc_q;
  assign fb        = bit_data ^ base[CRC_W-1];
  assign nxt       = {base[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  assign zero_next = (nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= '0;
    else if (clr)   crc_q <= '0;
    else if (take)  crc_q <= nxt;
  end
endmodule

// File: rtl/vbi_aspect_capture.sv
module vbi_aspect_capture
  import vbi_cap_pkg::*;
#(
  parameter int               LINE_W    = 10,
  parameter int               NOM_F0    = 20,
  parameter int               NOM_F1    = 283,
  parameter int               WORD_BITS = 20,
  parameter int               CRC_W     = 6,
  parameter logic [CRC_W-1:0] CRC_POLY  = 6'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field,
  input  logic              narrow,
  input  logic              clr,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              bit_ready,
  output logic              full_flag,
  output logic              lbox_flag,
  output logic              word_ok
);
  logic    in_win, offer, take, first, last, zero_next;
  aspect_t cap_q, held_q;
  logic    ok_q;

  assign bit_ready = !clr;
  assign offer     = bit_valid && bit_ready && in_win;

  vbi_line_gate #(.LINE_W(LINE_W), .NOM_F0(NOM_F0), .NOM_F1(NOM_F1)) u_gate (
    .line_num(line_num), .field(field), .narrow(narrow), .in_win(in_win)
  );

  vbi_word_track #(.LINE_W(LINE_W), .WORD_BITS(WORD_BITS)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(clr), .line_num(line_num), .offer(offer),
    .bit_data(bit_data), .take(take), .first(first), .last(last), .cap_q(cap_q)
  );

  vbi_crc_lfsr #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .first(first),
    .bit_data(bit_data), .zero_next(zero_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      ok_q   <= 1'b0;
    end else if (clr) begin
      held_q <= '0;
      ok_q   <= 1'b0;
    end else if (last) begin
      ok_q <= zero_next;
      if (zero_next) held_q <= cap_q;
    end
  end

  assign full_flag = held_q.full;
  assign lbox_flag = held_q.lbox;
  assign word_ok   = ok_q;
endmodule

// File: rtl/vbi_aspect_capture_chk.sv
module vbi_aspect_capture_chk #(
  parameter int LINE_W = 10,
  parameter int NOM_F0 = 20,
  parameter int NOM_F1 = 283
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINE_W-1:0] line_num,
  input logic              field,
  input logic              clr,
  input logic              bit_valid,
  input logic              bit_ready,
  input logic              full_flag,
  input logic              lbox_flag,
  input logic              word_ok
);
  int  nom;
  logic far;
  assign nom = field ? NOM_F1 : NOM_F0;
  assign far = (int'(line_num) < nom - 1) || (int'(line_num) > nom + 1);

  p_far_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (far && !clr) |=> $stable({full_flag, lbox_flag, word_ok}));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bit_valid && bit_ready) && !clr) |=> $stable({full_flag, lbox_flag, word_ok}));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!full_flag && !lbox_flag && !word_ok));

  p_ok_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_ok) |-> $past(bit_valid && bit_ready));

  p_fail_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(word_ok) && !$past(clr)) |-> $stable({full_flag, lbox_flag}));

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr) |-> !bit_ready);
endmodule

bind vbi_aspect_capture vbi_aspect_capture_chk #(
  .LINE_W(LINE_W), .NOM_F0(NOM_F0), .NOM_F1(NOM_F1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_num(line_num), .field(field), .clr(clr),
  .bit_valid(bit_valid), .bit_ready(bit_ready), .full_flag(full_flag),
  .lbox_flag(lbox_flag), .word_ok(word_ok)
);

// File: tb/sim_vbi_aspect_capture.sv
`timescale 1ns/1ps
module sim_vbi_aspect_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] line_num = '0;
  logic       field = 1'b0, narrow = 1'b1, clr = 1'b0;
  logic       bit_valid = 1'b0, bit_data = 1'b0;
  logic       bit_ready, full_flag, lbox_flag, word_ok;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  // reference model state
  int   m_prev = 0, m_cnt = 0;
  bit   m_full = 0, m_lbox = 0, m_ok = 0;
  bit   m_q[$];

  always #2.5 clk = ~clk;

  vbi_aspect_capture u0 (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .field(field), .narrow(narrow),
    .clr(clr), .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .full_flag(full_flag), .lbox_flag(lbox_flag), .word_ok(word_ok)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // remainder of payload * x^6 divided by x^6+x+1
  function automatic logic [19:0] mkword(input logic [13:0] pl);
    logic [19:0] v;
    v = {pl, 6'b0};
    for (int i = 19; i >= 6; i--)
      if (v[i]) v = v ^ (20'b1000011 << (i - 6));
    return {pl, v[5:0]};
  endfunction

  function automatic bit model_win(input int ln, input bit f, input bit nar);
    int d;
    d = ln - (f ? 283 : 20);
    return (d == 0) || (!nar && (d == 1 || d == -1));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_prev = 0; m_cnt = 0; m_full = 0; m_lbox = 0; m_ok = 0; m_q.delete();
    end else begin
      if (int'(line_num) != m_prev) begin m_cnt = 0; m_q.delete(); end
      m_prev = int'(line_num);
      if (clr) begin
        m_cnt = 0; m_q.delete(); m_full = 0; m_lbox = 0; m_ok = 0;
      end else if (bit_valid && model_win(int'(line_num), field, narrow) && m_cnt < 20) begin
        m_q.push_back(bit_data);
        m_cnt++;
        if (m_cnt == 20) begin
          logic [13:0] pl;
          logic [19:0] rx;
          for (int i = 0; i < 20; i++) rx[19-i] = m_q[i];
          pl = rx[19:6];
          if (mkword(pl) == rx) begin
            m_full = rx[19]; m_lbox = rx[18]; m_ok = 1;
          end else m_ok = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 model full_flag", full_flag, m_full);
      chk("R7 model lbox_flag", lbox_flag, m_lbox);
      chk("R7 model word_ok", word_ok, m_ok);
      chk("R10 model bit_ready", bit_ready, !clr);
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic send(input int ln, input bit f, input logic [19:0] w, input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_num = 10'(ln); field = f; bit_valid = 1'b1; bit_data = w[19-i];
      if (gap) begin @(negedge clk); bit_valid = 1'b0; end
    end
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic expect3(input string tag, input bit ef, input bit el, input bit eo);
    #1;
    chk({tag, " full"}, full_flag, ef);
    chk({tag, " lbox"}, lbox_flag, el);
    chk({tag, " ok"}, word_ok, eo);
  endtask

  initial begin
    logic [19:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R9 reset full", full_flag, 0);
    chk("R9 reset lbox", lbox_flag, 0);
    chk("R9 reset ok", word_ok, 0);
    chk("R9 reset ready", bit_ready, 1);

    // R1 R4 R5: full-mode word on line 20 of the first field
    send(20, 0, mkword(14'b10_0110_1011_0010), 20, 0);
    expect3("R5 line20", 1, 0, 1);

    // R1: letterbox word on line 283, second field, with gaps
    send(283, 1, mkword(14'b01_1100_0101_1110), 20, 1);
    expect3("R4 line283", 0, 1, 1);

    // R1: neighbour line in narrow mode is ignored
    send(21, 0, mkword(14'b11_0000_0000_0001), 20, 0);
    expect3("R1 narrow line21", 0, 1, 1);

    // R1: nominal line of the other field is ignored
    send(20, 1, mkword(14'b11_1111_0000_1111), 20, 0);
    expect3("R1 wrong field", 0, 1, 1);

    // R2: wide window accepts line 19
    narrow = 1'b0;
    send(19, 0, mkword(14'b11_0101_0101_0101), 20, 0);
    expect3("R2 line19", 1, 1, 1);

    // R6: corrupted code bit
    w = mkword(14'b00_1010_1010_1010);
    w[2] = ~w[2];
    send(20, 0, w, 20, 0);
    expect3("R6 bad code", 1, 1, 0);

    // R3: partial word on 282, then whole word on 283 plus trailing bits
    send(282, 1, mkword(14'b11_0000_1111_0000), 10, 0);
    expect3("R3 partial", 1, 1, 0);
    w = mkword(14'b10_1111_0000_1100);
    send(283, 1, w, 20, 0);
    expect3("R3 restart", 1, 0, 1);
    send(283, 1, 20'hF0F0F, 15, 0);
    expect3("R3 trailing", 1, 0, 1);

    // R3: a word split across a line change never completes
    send(284, 1, mkword(14'b01_0000_0000_0000), 12, 0);
    send(283, 1, mkword(14'b01_0000_0000_0000), 8, 0);
    expect3("R3 split", 1, 0, 1);

    // R8 R10: clear mid-word
    send(20, 0, mkword(14'b01_1111_1111_1111), 8, 0);
    @(negedge clk);
    clr = 1'b1; bit_valid = 1'b1; #1;
    chk("R10 ready low", bit_ready, 0);
    @(negedge clk);
    clr = 1'b0; bit_valid = 1'b0;
    expect3("R8 cleared", 0, 0, 0);
    send(20, 0, mkword(14'b01_1111_1111_1111), 20, 0);
    expect3("R8 after clear", 0, 1, 1);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule